// File: doc/BRIEF.md
# Row-by-Row Page Erase Sequencer

This block steps through the rows of a paged non-volatile array and erases them one at a time. An erase command carries a 16-bit target whose upper 11 bits select the starting row. The lower 5 bits would pick a 64-bit block inside the row. Because erasure always covers a whole 2048-bit row, those 5 bits are dropped. Once started, the sequencer spends one row-clock period on each row. It pulses an erase strobe toward the array port together with the row address, then moves on to the next row.

The row clock `row_clk` is the pin a host watches to count progress. It idles high and goes low for a fixed share at the end of every row period. Its period depends on a 2-bit sample-rate code, which is captured when the erase starts. The run has no length field. The host counts row-clock pulses and sends a stop command before the pulse of the last row it wants erased. The row in flight then completes on its boundary and the sequencer halts. If the run reaches the last row of the array without a stop, the sequencer halts by itself and raises a sticky overflow flag.

Top module: `row_erase_seq`

## Requirements
- R1: After reset `row_clk` is 1, while `busy`, `erase_stb`, `overflow` and `row_addr` are all 0.
- R2: A command with `cmd_valid`=1 and `cmd_byte`=8'hD1, taken while idle, starts a run at the next clock edge. At that edge `busy` rises, `erase_stb` pulses and `row_addr` takes `cmd_addr[15:5]`. The value of `cmd_addr[4:0]` has no effect.
- R3: A row lasts 10 sample periods. A sample period is 3*CLK_HZ divided by 24000, 19200, 16000 or 12000 clock cycles, for `rate_sel` codes 00, 01, 10 and 11. With the default CLK_HZ=64000 a row lasts 80, 100, 120 or 160 cycles.
- R4: `row_clk` is 0 during the last 2 sample periods of every row and 1 at all other times, including while idle.
- R5: Every row of a run produces exactly one single-cycle `erase_stb` pulse. The `row_addr` value rises by one from each row to the next and holds steady within a row.
- R6: A command with byte 8'hC0 during a run lets the current row finish. `busy` then falls at that row's boundary and no further row starts.
- R7: `rate_sel` is sampled only when a run starts. Changing it during a run does not alter the row timing.
- R8: An erase command during a run is ignored. A stop command while idle is ignored. Command bytes other than 8'hD1 and 8'hC0 are ignored.
- R9: When row 2047 finishes with no stop pending, the run ends and `overflow` goes to 1. It stays 1 until the next accepted erase command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_byte | input | 8 | Command code (8'hD1 start erase, 8'hC0 stop) |
| cmd_addr | input | 16 | Erase target: row in [15:5], block field in [4:0] (ignored) |
| rate_sel | input | 2 | Sample-rate code, captured when a run starts |
| row_clk | output | 1 | Row clock pin; low for the tail of each row |
| row_addr | output | 11 | Row currently being erased |
| erase_stb | output | 1 | One-cycle pulse at the start of each row erase |
| busy | output | 1 | A run is in progress |
| overflow | output | 1 | Sticky: a run passed the last row of the array |

## Verification
An accepted command shows its effect one edge after it is sampled: `busy`, the first strobe and the start row all appear in that cycle. Each later strobe follows the previous one by exactly one row period. A stopped run keeps `busy` high for exactly the number of finished rows times the row period. The driver sets inputs on the falling edge and samples outputs there. The scoreboard measures strobe spacing in cycles and matches it against the period for the captured rate. The driver also counts `busy` and `row_clk`-low samples over each run and compares them to rows times period and rows times low time.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    localparam logic [7:0] OP_ERASE = 8'hD1;
    localparam logic [7:0] OP_STOP  = 8'hC0;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // three times the sample rate in Hz, so 5.333 kHz stays an integer
    function automatic int unsigned rate_x3_hz(input logic [1:0] code);
        case (code)
            2'b00:   return 24000;
            2'b01:   return 19200;
            2'b10:   return 16000;
            default: return 12000;
        endcase
    endfunction

    function automatic int unsigned clks_per_sample(input int unsigned clk_hz,
                                                    input logic [1:0] code);
        return (3 * clk_hz) / rate_x3_hz(code);
    endfunction

endpackage

// File: rtl/erase_seq_cmd_dec.sv
module erase_seq_cmd_dec
    import erase_seq_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       erase_req,
    output logic       stop_req
);

    always_comb begin
        erase_req = cmd_valid && (cmd_byte == OP_ERASE);
        stop_req  = cmd_valid && (cmd_byte == OP_STOP);
    end

endmodule

// File: rtl/erase_seq_rate_tbl.sv
module erase_seq_rate_tbl
    import erase_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 64000,
    parameter int unsigned ROW_SAMPLES = 10,
    parameter int unsigned LOW_SAMPLES = 2,
    parameter int unsigned CNT_W       = 8
) (
    input  logic [1:0]       rate_code,
    output logic [CNT_W-1:0] row_last,
    output logic [CNT_W-1:0] high_len
);

    localparam int unsigned NUM_RATES = 4;

    logic [CNT_W-1:0] last_tbl [NUM_RATES];
    logic [CNT_W-1:0] high_tbl [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned DIV = clks_per_sample(CLK_HZ, 2'(g));
        assign last_tbl[g] = CNT_W'(DIV * ROW_SAMPLES - 1);
        assign high_tbl[g] = CNT_W'(DIV * (ROW_SAMPLES - LOW_SAMPLES));
    end

    always_comb begin
        row_last = last_tbl[rate_code];
        high_len = high_tbl[rate_code];
    end

endmodule

// File: rtl/erase_seq_row_timer.sv
module erase_seq_row_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_next,
    input  logic             clear,
    input  logic [CNT_W-1:0] row_last,
    input  logic [CNT_W-1:0] high_len,
    output logic             row_end,
    output logic             rac
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rac;
    } tmr_regs_t;

    tmr_regs_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (clear || !run_next) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
        // look one cycle ahead so the pin itself is a flop output
        t_d.rac = !(run_next && (t_d.cnt >= high_len));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= '0;
            t_q.rac <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign row_end = (t_q.cnt == row_last);
    assign rac     = t_q.rac;

endmodule

// File: rtl/row_erase_seq.sv
module row_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 64000,
    parameter int unsigned ROW_BITS    = 11,
    parameter int unsigned BLK_BITS    = 5,
    parameter int unsigned ROW_SAMPLES = 10,
    parameter int unsigned LOW_SAMPLES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [7:0]                   cmd_byte,
    input  logic [ROW_BITS+BLK_BITS-1:0] cmd_addr,
    input  logic [1:0]                   rate_sel,
    output logic                         row_clk,
    output logic [ROW_BITS-1:0]          row_addr,
    output logic                         erase_stb,
    output logic                         busy,
    output logic                         overflow
);

    localparam int unsigned ADDR_W       = ROW_BITS + BLK_BITS;
    localparam int unsigned MAX_ROW_CLKS = clks_per_sample(CLK_HZ, 2'b11) * ROW_SAMPLES;
    localparam int unsigned CNT_W        = $clog2(MAX_ROW_CLKS + 1);
    localparam logic [ROW_BITS-1:0] LAST_ROW = '1;

    typedef struct packed {
        seq_state_e          state;
        logic [ROW_BITS-1:0] row;
        logic                stop_pend;
        logic [1:0]          rate;
        logic                ovf;
        logic                stb;
    } seq_regs_t;

    localparam seq_regs_t REG_RST = '{state: SEQ_IDLE, row: '0, stop_pend: 1'b0,
                                      rate: 2'b00, ovf: 1'b0, stb: 1'b0};

    seq_regs_t r_q, r_d;

    logic             erase_req, stop_req;
    logic [CNT_W-1:0] row_last, high_len;
    logic             row_end, tmr_clear, run_next, rac;
    logic             unused_blk_bits;

    assign unused_blk_bits = ^cmd_addr[BLK_BITS-1:0];

    erase_seq_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .erase_req (erase_req),
        .stop_req  (stop_req)
    );

    erase_seq_rate_tbl #(
        .CLK_HZ      (CLK_HZ),
        .ROW_SAMPLES (ROW_SAMPLES),
        .LOW_SAMPLES (LOW_SAMPLES),
        .CNT_W       (CNT_W)
    ) u_rate (
        .rate_code (r_q.rate),
        .row_last  (row_last),
        .high_len  (high_len)
    );

    always_comb begin
        r_d       = r_q;
        r_d.stb   = 1'b0;
        tmr_clear = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (erase_req) begin
                    r_d.state     = SEQ_RUN;
                    r_d.row       = cmd_addr[ADDR_W-1:BLK_BITS];
                    r_d.stop_pend = 1'b0;
                    r_d.rate      = rate_sel;
                    r_d.ovf       = 1'b0;
                    r_d.stb       = 1'b1;
                    tmr_clear     = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (stop_req) begin
                    r_d.stop_pend = 1'b1;
                end
                if (row_end) begin
                    if (r_q.stop_pend || stop_req) begin
                        r_d.state = SEQ_IDLE;
                    end else if (r_q.row == LAST_ROW) begin
                        r_d.state = SEQ_IDLE;
                        r_d.ovf   = 1'b1;
                    end else begin
                        r_d.row   = r_q.row + 1'b1;
                        r_d.stb   = 1'b1;
                        tmr_clear = 1'b1;
                    end
                end
            end
            default: r_d = REG_RST;
        endcase
        run_next = (r_d.state == SEQ_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REG_RST;
        end else begin
            r_q <= r_d;
        end
    end

    erase_seq_row_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_next (run_next),
        .clear    (tmr_clear),
        .row_last (row_last),
        .high_len (high_len),
        .row_end  (row_end),
        .rac      (rac)
    );

    assign row_clk   = rac;
    assign row_addr  = r_q.row;
    assign erase_stb = r_q.stb;
    assign busy      = (r_q.state == SEQ_RUN);
    assign overflow  = r_q.ovf;

endmodule

// File: rtl/row_erase_seq_chk.sv
module row_erase_seq_chk #(
    parameter int unsigned ROW_BITS = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                row_clk,
    input logic [ROW_BITS-1:0] row_addr,
    input logic                erase_stb,
    input logic                busy,
    input logic                overflow
);

    AST_RUN_OPENS_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> erase_stb);  // R2

    AST_STB_ONLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> busy);  // R2

    AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> row_clk);  // R4

    AST_PIN_RISES_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_clk) |-> (erase_stb || !busy));  // R4

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |=> !erase_stb);  // R5

    AST_ROW_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_stb && $past(busy)) |-> (row_addr == ROW_BITS'($past(row_addr) + 1'b1)));  // R5

    AST_ROW_HELD_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !erase_stb) |-> $stable(row_addr));  // R5

    AST_NO_OVERFLOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !busy);  // R9

endmodule

bind row_erase_seq row_erase_seq_chk #(.ROW_BITS(ROW_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_clk   (row_clk),
    .row_addr  (row_addr),
    .erase_stb (erase_stb),
    .busy      (busy),
    .overflow  (overflow)
);

// File: tb/row_erase_seq_tb_top.sv
module row_erase_seq_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int CLK_HZ      = 64000;
    localparam int ROW_SAMPLES = 10;
    localparam int LOW_SAMPLES = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [15:0] cmd_addr = 16'h0000;
    logic [1:0]  rate_sel = 2'b00;
    logic        row_clk;
    logic [10:0] row_addr;
    logic        erase_stb;
    logic        busy;
    logic        overflow;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_rows[$];
    int exp_gap = 0;
    bit mon_first = 1'b1;
    int last_stb = 0;
    int mon_exp = 0;

    row_erase_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd_addr  (cmd_addr),
        .rate_sel  (rate_sel),
        .row_clk   (row_clk),
        .row_addr  (row_addr),
        .erase_stb (erase_stb),
        .busy      (busy),
        .overflow  (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clk_div(input logic [1:0] code);
        int x3;
        case (code)
            2'b00:   x3 = 24000;
            2'b01:   x3 = 19200;
            2'b10:   x3 = 16000;
            default: x3 = 12000;
        endcase
        return (3 * CLK_HZ) / x3;
    endfunction

    // monitor: pops one expected row per strobe and checks spacing
    always @(negedge clk) begin
        if (rst_n && erase_stb) begin
            if (exp_rows.size() == 0) begin
                check(1'b0, "R5 unexpected strobe row", int'(row_addr), -1);
            end else begin
                mon_exp = exp_rows.pop_front();
                check(int'(row_addr) == mon_exp, "R5/R2 strobe row", int'(row_addr), mon_exp);
            end
            if (!mon_first)
                check(cyc - last_stb == exp_gap, "R3 strobe spacing", cyc - last_stb, exp_gap);
            mon_first = 1'b0;
            last_stb  = cyc;
        end
    end

    // driver: issues one erase run and pushes the rows it expects
    task automatic run_erase(input int row, input int blk, input logic [1:0] rate,
                             input int stop_at, input int n_rows,
                             input bit flip_rate, input bit poke, input bit exp_ovf);
        int p;
        int busy_n;
        int low_n;
        int stb_n;
        int it;
        p = clk_div(rate) * ROW_SAMPLES;
        for (int i = 0; i < n_rows; i++) exp_rows.push_back(row + i);
        exp_gap   = p;
        mon_first = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'hD1;
        cmd_addr  = {row[10:0], blk[4:0]};
        rate_sel  = rate;
        @(negedge clk);
        check(busy == 1'b1, "R2 busy one edge after command", int'(busy), 1);
        busy_n = 0; low_n = 0; stb_n = 0; it = 0;
        while (busy && it < 5000) begin
            busy_n++;
            if (!row_clk) low_n++;
            if (erase_stb) stb_n++;
            cmd_valid = 1'b0;
            if (flip_rate && it == 1) rate_sel = ~rate;
            if (poke && it == 2) begin
                cmd_valid = 1'b1; cmd_byte = 8'hD1; cmd_addr = 16'h0000;
            end
            if (stop_at != 0 && erase_stb && stb_n == stop_at) begin
                cmd_valid = 1'b1; cmd_byte = 8'hC0;
            end
            it++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(busy_n == n_rows * p, "R6/R3 busy length", busy_n, n_rows * p);
        check(low_n == n_rows * clk_div(rate) * LOW_SAMPLES, "R4 row_clk low cycles",
              low_n, n_rows * clk_div(rate) * LOW_SAMPLES);
        check(exp_rows.size() == 0, "R5 all expected rows strobed", exp_rows.size(), 0);
        check(overflow == exp_ovf, "R9 overflow after run", int'(overflow), int'(exp_ovf));
        check(row_clk == 1'b1, "R4 row_clk high when idle", int'(row_clk), 1);
        exp_rows.delete();
    endtask

    task automatic idle_cmd(input logic [7:0] code, input string req);
        int moved;
        moved = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = code;
        cmd_addr  = 16'h1234;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (busy || !row_clk || erase_stb) moved++;
            @(negedge clk);
        end
        check(moved == 0, req, moved, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(row_clk == 1'b1, "R1 reset row_clk", int'(row_clk), 1);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(erase_stb == 1'b0, "R1 reset erase_stb", int'(erase_stb), 0);
        check(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);
        check(row_addr == 11'd0, "R1 reset row_addr", int'(row_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R6: three rows at rate 00, block bits set and ignored
        run_erase(5, 31, 2'b00, 3, 3, 1'b0, 1'b0, 1'b0);
        // R3 the other rate codes
        run_erase(100, 0, 2'b01, 2, 2, 1'b0, 1'b0, 1'b0);
        run_erase(200, 7, 2'b10, 1, 1, 1'b0, 1'b0, 1'b0);
        run_erase(300, 0, 2'b11, 2, 2, 1'b0, 1'b0, 1'b0);
        // R7 rate changed mid-run
        run_erase(40, 0, 2'b00, 2, 2, 1'b1, 1'b0, 1'b0);
        // R8 erase command during a run
        run_erase(60, 0, 2'b10, 3, 3, 1'b0, 1'b1, 1'b0);
        // R8 stop and unknown bytes while idle
        idle_cmd(8'hC0, "R8 stop while idle ignored");
        idle_cmd(8'h55, "R8 unknown byte ignored");
        // R9 run off the end of the array
        run_erase(2046, 0, 2'b00, 0, 2, 1'b0, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        check(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
        run_erase(10, 0, 2'b00, 1, 1, 1'b0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule